// File: doc/BRIEF.md
# Quarter-Phase Bus Pattern Output Stage

This block turns a stream of control words into levels on six general-purpose external bus lines. It runs on a clock four times faster than the bus clock, so each bus cycle has four quarter phases, numbered 1 to 4. Each word is taken at the end of quarter phase 4. During the next bus cycle it sets one level on every line for phases 1–2 and another level for phases 3–4.

Line 4 has two modes. With its mode bit clear it is an ordinary output. With the mode bit set the line is released and its pad becomes an external wait input. The two line-4 fields of the word then change meaning: the first-half bit picks the point where read data is sampled, and the second-half bit enables the wait. An enabled and asserted wait freezes the phase counter, the current word and every output level until the wait is seen released.

The block also gives a one-clock data-sample strobe for words marked as reads, a consume pulse each time a word is taken, and a sticky flag that records a reserved line-0 code. Word storage and address sequencing are done elsewhere.

Top module: `qp_pattern_out`

## Requirements
- R1: After reset the quarter phase is 1, every line shows its idle level (default 6'b100001, bit n = line n), the strobe and the error flag are 0, and no word is taken.
- R2: The consume pulse `word_take_o` is high in quarter phase 4 whenever `word_valid_i` is high and no freeze is active. The word is loaded at that edge and governs the following four phases, so one word is used every four clocks.
- R3: Lines 1, 2, 3 and 5 drive their own bit directly. The word bits are line 1 at [4]/[5], line 2 at [6]/[7], line 3 at [8]/[9] and line 5 at [12]/[13], the first bit of each pair for phases 1–2 and the second for phases 3–4.
- R4: Line 0 uses a 2-bit code per half, [1:0] for phases 1–2 and [3:2] for phases 3–4. Code 2'b10 drives 0, code 2'b11 drives 1, and code 2'b00 drives the level on `l0_dflt_i`.
- R5: The reserved line-0 code 2'b01 drives the `l0_dflt_i` level. Loading a word that holds it in either half sets `cfg_err_o`, which then stays set until reset.
- R6: With no word loaded, every line holds its idle level and the quarter-phase counter keeps running, so a newly valid word is taken within 4 clocks.
- R7: With `wait_mode_i`=0, line 4 drives bits [10] (phases 1–2) and [11] (phases 3–4) and `line_oe_o[4]`=1. With `wait_mode_i`=1, `line_oe_o[4]`=0 and `line_o[4]`=0.
- R8: In wait mode, a loaded word with bit [11]=1 and the wait pad high, seen through a two-flop synchronizer, freezes the phase, `line_o` and the consume pulse. The third clock after the pad falls is the first one to advance again.
- R9: In wait mode, a word with bit [11]=0 ignores the wait pad, and words continue to be taken every four clocks.
- R10: For a read word (bit [14]=1) in wait mode with bit [10]=1, the strobe is one clock wide and comes in phase 3 of the same bus cycle, even when that phase is frozen.
- R11: For a read word with bit [10]=0, or with wait mode off, the strobe is one clock wide and comes in phase 1 of the next bus cycle.
- R12: A word with bit [14]=0 produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_i | input | 15 | Control word (fields in R3–R5, R7, R10–R12) |
| word_valid_i | input | 1 | A word is present on `word_i` |
| word_take_o | output | 1 | Word taken at this edge (consume pulse) |
| wait_mode_i | input | 1 | 1: line 4 is the wait input |
| l0_dflt_i | input | 1 | Default level for line 0 codes 00 and 01 |
| wait_pad_i | input | 1 | Asynchronous wait input from the line-4 pad |
| line_o | output | 6 | Line levels, bit n = line n |
| line_oe_o | output | 6 | Output enables, bit 4 low in wait mode |
| sample_stb_o | output | 1 | Read data sample strobe |
| cfg_err_o | output | 1 | Sticky reserved-code flag |

## Verification
The phase counter is internal, and an error in it appears at the ports within one bus cycle. A consume pulse that leaves quarter phase 4 moves every following half-cycle pattern out of line, and the vector table catches this on the next word. A freeze that is wrong in length or in scope changes the number of clocks between the wait release and the next consume pulse, which the bench counts exactly. A wrong sample-point flag moves the strobe to the wrong quarter or into the next cycle, and this is visible within four clocks.

// File: rtl/qp_pkg.sv
package qp_pkg;
   localparam int QP_LINES  = 6;
   localparam int QP_WORD_W = 15;
   // field positions inside a control word
   localparam int F_L0_A   = 0;   // 2 bits, first half
   localparam int F_L0_B   = 2;   // 2 bits, second half
   localparam int F_PAIR0  = 4;   // line 1 pair; line n pair at F_PAIR0 + 2*(n-1)
   localparam int F_RD     = 14;
   localparam int L_WAIT   = 4;   // line that doubles as wait input
   localparam int F_SEL    = F_PAIR0 + 2*(L_WAIT-1);
   localparam int F_WEN    = F_SEL + 1;

   typedef logic [1:0] qphase_t;

   function automatic logic l0_level(input logic [1:0] code, input logic dflt);
      case (code)
         2'b10:   return 1'b0;
         2'b11:   return 1'b1;
         default: return dflt;   // 00 and reserved 01
      endcase
   endfunction
endpackage

// File: rtl/qp_wait_sync.sv
module qp_wait_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("qp_wait_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], async_i};
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/qp_phase_ctl.sv
module qp_phase_ctl
   import qp_pkg::*;
#(
   parameter int WORD_W = QP_WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stall_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              word_valid_i,
   output logic              take_o,
   output logic              adv_o,
   output qphase_t           phase_o,
   output logic [WORD_W-1:0] cur_word_o,
   output logic              cur_vld_o,
   output logic              err_o
);
   if (WORD_W != QP_WORD_W) begin : g_bad_width
      $error("qp_phase_ctl: WORD_W must match the word layout");
   end

   qphase_t           phase_q;
   logic [WORD_W-1:0] cur_q;
   logic              vld_q;
   logic              err_q;
   logic              reserved_seen;

   assign adv_o  = !stall_i;
   assign take_o = word_valid_i && adv_o && (phase_q == 2'd3);

   assign reserved_seen = (word_i[F_L0_A +: 2] == 2'b01) ||
                          (word_i[F_L0_B +: 2] == 2'b01);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 2'd0;
         cur_q   <= '0;
         vld_q   <= 1'b0;
         err_q   <= 1'b0;
      end else if (adv_o) begin
         phase_q <= phase_q + 2'd1;
         if (phase_q == 2'd3) begin
            vld_q <= word_valid_i;
            if (word_valid_i) cur_q <= word_i;
         end
         if (take_o && reserved_seen) err_q <= 1'b1;
      end
   end

   assign phase_o    = phase_q;
   assign cur_word_o = cur_q;
   assign cur_vld_o  = vld_q;
   assign err_o      = err_q;

   // R8: a freeze holds the quarter phase
   a_r8_phase_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      stall_i |=> $stable(phase_o));
   // R2: consumption only at quarter phase 4
   a_r2_take_in_q4: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (phase_o == 2'd3));
   // R5: error flag never clears
   a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);
endmodule

// File: rtl/qp_line_mux.sv
module qp_line_mux
   import qp_pkg::*;
#(
   parameter logic [QP_LINES-1:0] IDLE_LVL = 6'b100001
) (
   input  qphase_t               phase_i,
   input  logic [QP_WORD_W-1:0]  cur_word_i,
   input  logic                  cur_vld_i,
   input  logic                  wait_mode_i,
   input  logic                  l0_dflt_i,
   output logic [QP_LINES-1:0]   line_o,
   output logic [QP_LINES-1:0]   line_oe_o
);
   logic second_half;
   assign second_half = phase_i[1];

   logic [QP_LINES-1:0] act;

   always_comb begin
      act[0] = second_half ? l0_level(cur_word_i[F_L0_B +: 2], l0_dflt_i)
                           : l0_level(cur_word_i[F_L0_A +: 2], l0_dflt_i);
   end

   for (genvar n = 1; n < QP_LINES; n++) begin : g_line
      localparam int BA = F_PAIR0 + 2*(n-1);
      if (n == L_WAIT) begin : g_dual
         logic lvl;
         assign lvl = second_half ? cur_word_i[BA+1] : cur_word_i[BA];
         assign act[n]       = wait_mode_i ? 1'b0 : lvl;
         assign line_oe_o[n] = !wait_mode_i;
         assign line_o[n]    = wait_mode_i ? 1'b0 : (cur_vld_i ? act[n] : IDLE_LVL[n]);
      end else begin : g_plain
         assign act[n]       = second_half ? cur_word_i[BA+1] : cur_word_i[BA];
         assign line_oe_o[n] = 1'b1;
         assign line_o[n]    = cur_vld_i ? act[n] : IDLE_LVL[n];
      end
   end

   assign line_oe_o[0] = 1'b1;
   assign line_o[0]    = cur_vld_i ? act[0] : IDLE_LVL[0];
endmodule

// File: rtl/qp_sample_gen.sv
module qp_sample_gen
   import qp_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  qphase_t              phase_i,
   input  logic                 adv_i,
   input  logic [QP_WORD_W-1:0] cur_word_i,
   input  logic                 cur_vld_i,
   input  logic                 wait_mode_i,
   output logic                 stb_o
);
   logic is_read, early_sel, hit_now, pend_set;
   logic pend_q, fired_q;

   assign is_read   = cur_vld_i && cur_word_i[F_RD];
   assign early_sel = wait_mode_i && cur_word_i[F_SEL];
   assign hit_now   = is_read && early_sel && (phase_i == 2'd2) && !fired_q;
   assign pend_set  = adv_i && (phase_i == 2'd3) && is_read && !early_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         fired_q <= 1'b0;
      end else begin
         pend_q <= pend_set;
         if (adv_i && phase_i == 2'd3) fired_q <= 1'b0;
         else if (hit_now)             fired_q <= 1'b1;
      end
   end

   assign stb_o = hit_now || (pend_q && phase_i == 2'd0);

   // R10/R11: strobe is a single clock wide
   a_r10_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
      stb_o |=> !stb_o);
   // R11: deferred strobe only in quarter phase 1
   a_r11_pend_q1: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_o && !early_sel) |-> (phase_i == 2'd0));
endmodule

// File: rtl/qp_pattern_out.sv
module qp_pattern_out
   import qp_pkg::*;
#(
   parameter int                  SYNC_STAGES = 2,
   parameter logic [QP_LINES-1:0] IDLE_LVL    = 6'b100001
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [QP_WORD_W-1:0] word_i,
   input  logic                 word_valid_i,
   output logic                 word_take_o,
   input  logic                 wait_mode_i,
   input  logic                 l0_dflt_i,
   input  logic                 wait_pad_i,
   output logic [QP_LINES-1:0]  line_o,
   output logic [QP_LINES-1:0]  line_oe_o,
   output logic                 sample_stb_o,
   output logic                 cfg_err_o
);
   logic                 wait_s;
   logic                 stall;
   logic                 adv;
   qphase_t              phase;
   logic [QP_WORD_W-1:0] cur_word;
   logic                 cur_vld;

   qp_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_i(wait_pad_i), .sync_o(wait_s));

   assign stall = wait_mode_i && cur_vld && cur_word[F_WEN] && wait_s;

   qp_phase_ctl #(.WORD_W(QP_WORD_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .stall_i(stall),
      .word_i(word_i), .word_valid_i(word_valid_i),
      .take_o(word_take_o), .adv_o(adv), .phase_o(phase),
      .cur_word_o(cur_word), .cur_vld_o(cur_vld), .err_o(cfg_err_o));

   qp_line_mux #(.IDLE_LVL(IDLE_LVL)) u_mux (
      .phase_i(phase), .cur_word_i(cur_word), .cur_vld_i(cur_vld),
      .wait_mode_i(wait_mode_i), .l0_dflt_i(l0_dflt_i),
      .line_o(line_o), .line_oe_o(line_oe_o));

   qp_sample_gen u_smp (
      .clk(clk), .rst_n(rst_n), .phase_i(phase), .adv_i(adv),
      .cur_word_i(cur_word), .cur_vld_i(cur_vld), .wait_mode_i(wait_mode_i),
      .stb_o(sample_stb_o));

   // R8: frozen output levels hold while configuration is steady
   a_r8_lines_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> ($stable(line_o) || !$stable(wait_mode_i) || !$stable(l0_dflt_i)));
   // R8: no word consumed during a freeze
   a_r8_no_take_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> !word_take_o);
endmodule

// File: tb/qp_pattern_out_tb_top.sv
`timescale 1ns/1ps
module qp_pattern_out_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] word = '0;
   logic        valid = 1'b0;
   logic        take;
   logic        wmode = 1'b0;
   logic        dflt = 1'b1;
   logic        wpad = 1'b0;
   logic [5:0]  lines, oe;
   logic        stb, err;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   localparam logic [5:0] IDLE = 6'b100001;

   always #2.5 clk = ~clk;

   qp_pattern_out dut_i (
      .clk(clk), .rst_n(rst_n), .word_i(word), .word_valid_i(valid),
      .word_take_o(take), .wait_mode_i(wmode), .l0_dflt_i(dflt),
      .wait_pad_i(wpad), .line_o(lines), .line_oe_o(oe),
      .sample_stb_o(stb), .cfg_err_o(err));

   // {word, first-half lines, second-half lines}, wait mode off, default level 1
   localparam logic [26:0] VEC [5] = '{
      {15'b001101110011011, 6'b101011, 6'b011100},
      {15'b010010001101100, 6'b010101, 6'b100011},
      {15'b000000000000010, 6'b000000, 6'b000001},
      {15'b011111111111111, 6'b111111, 6'b111111},
      {15'b001010101010000, 6'b111111, 6'b000001}
   };

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic sync_take(input string tag);
      for (int k = 0; k < 8 && !take; k++) step();
      chk(take, 1, tag);
   endtask

   int cnt;

   initial begin
      #200000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk(lines, IDLE, "R1 idle lines");
      chk(stb, 0, "R1 strobe");
      chk(err, 0, "R1 error flag");
      chk(take, 0, "R1 no take");
      chk(oe, 6'b111111, "R1 enables");

      // table walk: R2, R3, R4, R7 (mode 0)
      valid = 1'b1;
      for (int i = 0; i < 5; i++) begin
         word = VEC[i][26:12];
         sync_take("R2 take in phase 4");
         step(); chk(lines, VEC[i][11:6], "R3/R4 phase 1");
         step(); chk(lines, VEC[i][11:6], "R3/R4 phase 2");
         chk(take, 0, "R2 no take mid cycle");
         step(); chk(lines, VEC[i][5:0], "R3/R4 phase 3");
         step(); chk(lines, VEC[i][5:0], "R7 line4 mode0 phase 4");
         chk(take, 1, "R2 take every four clocks");
      end
      chk(err, 0, "R5 no error without reserved code");

      // R6 idle levels and running counter
      valid = 1'b0;
      step(); chk(lines, IDLE, "R6 idle after stream ends");
      step(); step();
      chk(lines, IDLE, "R6 idle held");
      word = 15'b000000000000001;   // line 0 reserved code first half
      valid = 1'b1;
      cnt = 0;
      while (!take && cnt < 8) begin step(); cnt++; end
      chk(cnt <= 4, 1, "R6 take within 4 clocks");
      step(); chk(lines[0], 1, "R5 reserved uses default");
      chk(err, 1, "R5 error flag set");
      valid = 1'b0;
      step(); step(); step(); step();
      chk(err, 1, "R5 error flag sticky");
      dflt = 1'b0;
      word = 15'b000000000000000;
      valid = 1'b1;
      sync_take("R4 take");
      step(); chk(lines[0], 0, "R4 code 00 follows default input");

      // wait mode: freeze, sample in phase 3
      wmode = 1'b1;
      word = 15'b100110010011011;
      sync_take("R8 take");
      step();
      chk(lines, 6'b000011, "R7 first half wait mode");
      chk(oe[4], 0, "R7 line4 released");
      wpad = 1'b1;
      step(); chk(stb, 0, "R10 no strobe in phase 2");
      step(); chk(stb, 1, "R10 strobe in phase 3");
      chk(lines, 6'b000100, "R8 second half");
      for (int k = 0; k < 4; k++) begin
         step();
         chk(lines, 6'b000100, "R8 lines frozen");
         chk(take, 0, "R8 no take while frozen");
         chk(stb, 0, "R10 strobe single");
      end
      wpad = 1'b0;
      word = 15'b100000000001010;   // read, late sample, wait disabled
      cnt = 0;
      while (!take && cnt < 10) begin step(); cnt++; end
      chk(cnt, 3, "R8 resume latency");

      // R9 wait ignored, R11 deferred strobe
      step(); chk(stb, 0, "R11 no strobe phase 1 own cycle");
      wpad = 1'b1;
      step(); step(); chk(stb, 0, "R11 no strobe phase 3");
      step(); chk(take, 1, "R9 take despite wait pad");
      word = 15'b000000000001010;   // non-read
      step(); chk(stb, 1, "R11 strobe phase 1 next cycle");
      step(); chk(stb, 0, "R11 strobe single");
      step(); chk(stb, 0, "R12 no strobe non-read");
      step(); chk(stb, 0, "R12 no strobe non-read phase 4");
      chk(take, 1, "R9 still taking");
      chk(lines[4], 0, "R7 line4 low in wait mode");

      wpad = 1'b0;
      valid = 1'b0;
      step();
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule